// File: doc/BRIEF.md
# Complementary Dead-Time Pair Generator

This block turns one PWM waveform per channel pair into two complementary gate drives, with a blanking gap placed at every transition, so that a high-side and a low-side switch are never driven on together. Each pair has a dead-time enable, an 8-bit gap length, and a tick input. The tick strobes once for each period of the pair's divided timer clock. The gap is counted in those ticks, not in system clock cycles.

When a pair is enabled, the first channel's PWM is the source. The primary gate follows the source and the secondary gate follows its complement. The second channel's own PWM is then ignored. When a pair is disabled, each gate simply passes its own channel's PWM through. Several pairs are built side by side and run independently.

The core samples the source on the system clock. A source transition is seen one cycle after it appears at the pins, and both gates drop low at that point. The newly active gate rises on the clock edge at which the pair's gap counter has seen the programmed number of ticks. There is no streaming data path, so every pin is a plain level or strobe.

Top module: `dz_pair_gen`

## Requirements
- R1: While reset is asserted, both gates of an enabled pair are low. After reset the core treats the current source level as a fresh transition, so the first active gate rises only after the full gap has elapsed.
- R2: On a rising source transition with gap N > 0, both gates are low from the next clock edge onward. The primary gate rises on the clock edge of the N-th tick counted after the transition was seen, and the secondary gate stays low.
- R3: On a falling source transition with gap N > 0, both gates are low from the next clock edge onward. The secondary gate rises on the clock edge of the N-th tick counted after the transition was seen, and the primary gate stays low.
- R4: With a gap of 0, one clock edge after a transition the primary gate equals the source and the secondary gate equals its inverse, with no blank cycle.
- R5: A source transition that arrives while a gap is still being counted restarts the count from the full programmed length, and both gates stay low in the meantime.
- R6: While a pair is enabled, its two gates are never high together.
- R7: While a pair is disabled, the primary gate equals the first channel's PWM and the secondary gate equals the second channel's PWM in the same cycle. While a pair is enabled, the second channel's PWM has no effect on either gate.
- R8: Only clock cycles with the pair's tick high advance the gap count. Without ticks, both gates stay low indefinitely after a transition.
- R9: Each pair's gates depend only on that pair's own enable, gap, tick and PWM inputs. The gap of pair p sits in bits [8p+7:8p] of the gap bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dz_en | input | NPAIR | Per-pair dead-time enable |
| dz_gap | input | NPAIR*DZW | Per-pair gap length in ticks, pair p in bits [DZW*p+DZW-1:DZW*p] |
| dz_tick | input | NPAIR | Per-pair strobe, one cycle per divided timer clock period |
| pwm_a | input | NPAIR | First channel PWM of each pair (dead-time source) |
| pwm_b | input | NPAIR | Second channel PWM of each pair (used only when disabled) |
| gate_a | output | NPAIR | Primary gate drive |
| gate_b | output | NPAIR | Secondary (complementary) gate drive |

## Verification
The directed cases target the points where an off-by-one hides. A design that counted the detection edge as a tick, or stopped at N-1, would raise a gate one cycle early in the rising and falling gap tests. A retrigger in mid-gap catches a design that keeps the old count, which would raise a gate too soon, or one that lets the old gate through, which would give overlap. Starving the tick catches a design that counts system cycles instead of ticks. A zero gap catches one that inserts a blank cycle anyway. Long random runs with mixed enables, gaps, sparse ticks and toggling second-channel PWM compare every gate against a per-pair reference model. These runs expose crosstalk between pairs and any leakage of the second channel's PWM while a pair is enabled.

// File: rtl/dz_pkg.sv
package dz_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  localparam int unsigned DZ_DEF_W = 8;
endpackage

// File: rtl/dz_edge.sv
module dz_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic src_q,
  output logic fresh,
  output logic trans
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      fresh <= 1'b1;
    end else begin
      src_q <= src;
      fresh <= 1'b0;
    end
  end

  assign trans = fresh | (src ^ src_q);
endmodule

// File: rtl/dz_span.sv
module dz_span #(
  parameter int unsigned DZW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [DZW-1:0] gap,
  input  logic           tick,
  output logic           done
);
  localparam logic [DZW-1:0] ONE = DZW'(1);

  logic [DZW-1:0] cnt;
  logic           busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= gap;
      busy <= (gap != '0);
    end else if (busy && tick) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) busy <= 1'b0;
    end
  end

  assign done = busy & tick & (cnt == ONE) & ~load;

  // R2: a load captures the programmed gap length
  assert_gap_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(gap)));
  // R8: without a tick and without a load the count holds
  assert_count_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/dz_core.sv
module dz_core #(
  parameter int unsigned DZW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src,
  input  logic [DZW-1:0]     gap,
  input  logic               tick,
  output dz_pkg::gate_pair_t drv
);
  logic src_q, fresh, trans, done;
  logic out_hi, out_lo;

  dz_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src),
    .src_q (src_q),
    .fresh (fresh),
    .trans (trans)
  );

  dz_span #(.DZW(DZW)) u_span (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (trans),
    .gap   (gap),
    .tick  (tick),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hi <= 1'b0;
      out_lo <= 1'b0;
    end else if (trans) begin
      if (gap == '0) begin
        out_hi <= src;
        out_lo <= ~src;
      end else begin
        out_hi <= 1'b0;
        out_lo <= 1'b0;
      end
    end else if (done) begin
      out_hi <= src_q;
      out_lo <= ~src_q;
    end
  end

  assign drv.hi = out_hi;
  assign drv.lo = out_lo;

  // R5: a transition with a nonzero gap blanks both outputs
  assert_blank_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trans && gap != '0) |=> (!out_hi && !out_lo));
  // R4: zero gap gives the complement at once
  assert_zero_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trans && gap == '0) |=> (out_hi == $past(src) && out_lo == !$past(src)));
  // R8: no tick and no transition means the outputs hold
  assert_tick_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trans) |=> ($stable(out_hi) && $stable(out_lo)));
endmodule

// File: rtl/dz_pair_gen.sv
module dz_pair_gen #(
  parameter int unsigned NPAIR = 2,
  parameter int unsigned DZW   = dz_pkg::DZ_DEF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPAIR-1:0]     dz_en,
  input  logic [NPAIR*DZW-1:0] dz_gap,
  input  logic [NPAIR-1:0]     dz_tick,
  input  logic [NPAIR-1:0]     pwm_a,
  input  logic [NPAIR-1:0]     pwm_b,
  output logic [NPAIR-1:0]     gate_a,
  output logic [NPAIR-1:0]     gate_b
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    dz_pkg::gate_pair_t drv;

    dz_core #(.DZW(DZW)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (pwm_a[p]),
      .gap   (dz_gap[DZW*p +: DZW]),
      .tick  (dz_tick[p]),
      .drv   (drv)
    );

    assign gate_a[p] = dz_en[p] ? drv.hi : pwm_a[p];
    assign gate_b[p] = dz_en[p] ? drv.lo : pwm_b[p];

    // R6: an enabled pair never drives both gates high
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dz_en[p] |-> !(gate_a[p] && gate_b[p]));
  end
endmodule

// File: tb/dz_pair_gen_tb.sv
module dz_pair_gen_tb;
  localparam int NPAIR = 2;
  localparam int DZW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPAIR-1:0]     en = '0, tick = '0, pa = '0, pb = '0;
  logic [NPAIR*DZW-1:0] gap = '0;
  logic [NPAIR-1:0]     ga, gb;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dz_pair_gen #(.NPAIR(NPAIR), .DZW(DZW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dz_en(en), .dz_gap(gap), .dz_tick(tick),
    .pwm_a(pa), .pwm_b(pb), .gate_a(ga), .gate_b(gb)
  );

  // reference model, one state set per pair
  logic          m_src [NPAIR];
  logic          m_fresh [NPAIR];
  logic          m_a [NPAIR];
  logic          m_b [NPAIR];
  logic          m_busy [NPAIR];
  int unsigned   m_left [NPAIR];

  always @(posedge clk or negedge rst_n) begin
    for (int p = 0; p < NPAIR; p++) begin
      if (!rst_n) begin
        m_src[p] = 0; m_fresh[p] = 1; m_a[p] = 0; m_b[p] = 0;
        m_busy[p] = 0; m_left[p] = 0;
      end else begin
        int unsigned g;
        g = gap[DZW*p +: DZW];
        if (m_fresh[p] || pa[p] != m_src[p]) begin
          m_busy[p] = (g != 0);
          m_left[p] = g;
          m_a[p] = (g == 0) ? pa[p] : 1'b0;
          m_b[p] = (g == 0) ? ~pa[p] : 1'b0;
        end else if (m_busy[p] && tick[p]) begin
          m_left[p] = m_left[p] - 1;
          if (m_left[p] == 0) begin
            m_busy[p] = 0;
            m_a[p] = m_src[p];
            m_b[p] = ~m_src[p];
          end
        end
        m_src[p] = pa[p];
        m_fresh[p] = 0;
      end
    end
  end

  function automatic logic exp_a(int p);
    return en[p] ? m_a[p] : pa[p];
  endfunction
  function automatic logic exp_b(int p);
    return en[p] ? m_b[p] : pb[p];
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset holds enabled gates low
    en = 2'b01; gap[7:0] = 8'd3; tick = 2'b11; pa = 0; pb = 2'b10;
    settle(3);
    chk("R1", "gate_a in reset", ga[0], 1'b0);
    chk("R1", "gate_b in reset", gb[0], 1'b0);
    chk("R7", "pair1 disabled passes pwm_b", gb[1], 1'b1);
    rst_n = 1'b1;
    // fresh transition at edge 1, ticks at edges 2..4
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R1", "gate_b after reset gap", gb[0], i == 4);
      chk("R1", "gate_a after reset gap", ga[0], 1'b0);
    end

    // R2: rising edge, gap 3
    pa[0] = 1;
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R2", "gate_a rise timing", ga[0], i == 4);
      chk("R2", "gate_b stays low", gb[0], 1'b0);
    end

    // R3: falling edge, gap 3
    pa[0] = 0;
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R3", "gate_b rise timing", gb[0], i == 4);
      chk("R3", "gate_a stays low", ga[0], 1'b0);
    end

    // R4: zero gap, no blank cycle
    gap[7:0] = 8'd0;
    pa[0] = 1;
    step();
    chk("R4", "gate_a immediate", ga[0], 1'b1);
    chk("R4", "gate_b immediate", gb[0], 1'b0);
    pa[0] = 0;
    step();
    chk("R4", "gate_a immediate fall", ga[0], 1'b0);
    chk("R4", "gate_b immediate rise", gb[0], 1'b1);

    // R5: retrigger mid-gap restarts the count
    gap[7:0] = 8'd4;
    pa[0] = 1;
    settle(2);
    chk("R5", "blank before retrigger a", ga[0], 1'b0);
    chk("R5", "blank before retrigger b", gb[0], 1'b0);
    pa[0] = 0;
    for (int i = 1; i <= 5; i++) begin
      step();
      chk("R5", "gate_b after restart", gb[0], i == 5);
      chk("R5", "gate_a held low", ga[0], 1'b0);
    end

    // R8: no ticks, no progress
    gap[7:0] = 8'd3;
    tick[0] = 0;
    pa[0] = 1;
    for (int i = 0; i < 20; i++) begin
      step();
      chk("R8", "gate_a starved", ga[0], 1'b0);
      chk("R8", "gate_b starved", gb[0], 1'b0);
    end
    for (int k = 1; k <= 3; k++) begin
      tick[0] = 1; step();
      tick[0] = 0;
      chk("R8", "gate_a after tick", ga[0], k == 3);
      settle(2);
      chk("R8", "gate_a between ticks", ga[0], k == 3);
    end

    // R7: pwm_b ignored while enabled, passed through when disabled
    for (int i = 0; i < 4; i++) begin
      pb[0] = ~pb[0];
      #1;
      chk("R7", "gate_b ignores pwm_b", gb[0], 1'b0);
      chk("R7", "gate_a ignores pwm_b", ga[0], 1'b1);
      step();
    end
    en[0] = 0;
    for (int i = 0; i < 4; i++) begin
      pa[0] = i[0]; pb[0] = i[1];
      #1;
      chk("R7", "disabled gate_a", ga[0], i[0]);
      chk("R7", "disabled gate_b", gb[0], i[1]);
      step();
    end

    // random phase: both pairs against the model, fixed seed
    void'($urandom(32'h5EED_0D2A));
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NPAIR; p++) begin
        if ($urandom_range(0, 99) < 2) en[p] = ~en[p];
        if ($urandom_range(0, 99) < 3) gap[DZW*p +: DZW] = DZW'($urandom_range(0, 5));
        if ($urandom_range(0, 99) < 12) pa[p] = ~pa[p];
        if ($urandom_range(0, 99) < 30) pb[p] = ~pb[p];
        tick[p] = ($urandom_range(0, 99) < 60);
      end
      step();
      for (int p = 0; p < NPAIR; p++) begin
        chk("R9", "random gate_a", ga[p], exp_a(p));
        chk("R9", "random gate_b", gb[p], exp_b(p));
        if (en[p]) chk("R6", "no overlap", ga[p] & gb[p], 1'b0);
      end
    end

    finish_run();
  end
endmodule